// File: doc/BRIEF.md
# Mixed-Page-Size First-Level Address Translation Buffer

This block is a small fully associative cache of virtual-to-physical translations that sits beside a load/store or fetch pipeline. Each lookup presents a virtual address together with the current address-space tag and virtual-machine tag. In the same cycle the block returns a hit flag, a 40-bit physical address and the attribute bits stored with the matching entry. When nothing matches, the block raises a walk request toward the second-level translation buffer. That level later installs the missing translation through the fill port.

Each entry records its own page size, so a single array can hold 4 KiB, 16 KiB, 64 KiB, 2 MiB and one large page size chosen at build time side by side. Each entry also holds a global flag, an address-space tag and a virtual-machine tag. Because of these tags, a context switch or a virtual-machine switch does not require flushing the array. An invalidate port removes entries in one of four ways: all entries, entries of one address space, entries of one virtual machine, or entries matching both tags.

Top module: `l1_xlat_buf`

## Requirements
- R1: After reset every entry is invalid and the replacement pointer is at entry 0, so every valid lookup misses.
- R2: A lookup hits on a valid entry whose VMID equals `lk_vmid`, whose ASID equals `lk_asid` unless the entry's global flag is set, and whose virtual page bits at and above the entry's page size equal those of `lk_va`. Hit and data appear combinationally in the same cycle.
- R3: Page size code 0 selects 4 KiB (12 offset bits), code 1 selects 16 KiB (14), code 2 selects 64 KiB (16), code 3 selects 2 MiB (21) and code 4 selects the large size (`BIG_SHIFT` offset bits, default 25). Codes 5 to 7 behave as 4 KiB.
- R4: The physical address takes bits below the page size from `lk_va` and bits at and above it from the entry's frame number, which is stored as physical address bits 39:12.
- R5: `lk_attr` returns the stored attribute bits of the selected entry. On a miss, `lk_pa` and `lk_attr` are zero.
- R6: `walk_req` is high exactly when `lk_valid` is high and no entry hits. When `lk_valid` is low, `lk_hit`, `lk_multi` and `walk_req` are all low.
- R7: When more than one entry hits, `lk_multi` is high and the lowest-index hitting entry supplies the physical address and the attributes.
- R8: A fill writes the lowest-index invalid entry whenever one exists, and leaves the replacement pointer unchanged.
- R9: When every entry is valid, a fill writes the entry under the replacement pointer. The pointer then advances by one and wraps from `ENTRIES-1` to 0.
- R10: `inv_kind` 0 invalidates all entries. Kind 1 invalidates non-global entries whose ASID equals `inv_asid`. Kind 2 invalidates entries whose VMID equals `inv_vmid`. Kind 3 invalidates non-global entries where both tags match. All take effect at the next clock edge.
- R11: Invalidation by ASID (kind 1) leaves global entries valid, even when their stored ASID matches.
- R12: When a fill and an invalidate arrive in the same cycle, the victim is chosen from the state before the edge. The filled entry is valid afterwards, and the invalidate applies to all other entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space tag |
| lk_vmid | input | 16 | Current virtual-machine tag |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one entry hit |
| lk_pa | output | 40 | Translated physical address (zero on miss) |
| lk_attr | output | 8 | Attributes of the selected entry (zero on miss) |
| walk_req | output | 1 | Miss request toward the second-level buffer |
| fill_valid | input | 1 | Install an entry at the next edge |
| fill_vpn | input | 36 | Virtual address bits 47:12 of the new entry |
| fill_pfn | input | 28 | Physical address bits 39:12 of the new entry |
| fill_size | input | 3 | Page size code of the new entry |
| fill_global | input | 1 | Global flag of the new entry |
| fill_asid | input | 16 | ASID of the new entry |
| fill_vmid | input | 16 | VMID of the new entry |
| fill_attr | input | 8 | Attribute bits of the new entry |
| inv_valid | input | 1 | Invalidate at the next edge |
| inv_kind | input | 2 | Invalidate selector (0 all, 1 ASID, 2 VMID, 3 ASID and VMID) |
| inv_asid | input | 16 | ASID operand for invalidation |
| inv_vmid | input | 16 | VMID operand for invalidation |

## Verification
The replacement pointer only moves once the array is completely full. Its wrap from the last entry back to entry 0 therefore needs close to a hundred distinct fills after an invalidate-all. The stimulus issues those fills back to back, each with a distinct page, and then probes the oldest pages to see which ones were overwritten. A fill that lands in the same cycle as an invalidate-all, with the array full, is driven deliberately afterwards. Multi-hit is provoked by installing the same page twice. The reference model compares every output on every clock throughout.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int VA_W       = 48;
  localparam int PA_W       = 40;
  localparam int BASE_SHIFT = 12;
  localparam int VPN_W      = VA_W - BASE_SHIFT;
  localparam int PFN_W      = PA_W - BASE_SHIFT;
  localparam int ASID_W     = 16;
  localparam int VMID_W     = 16;
  localparam int ATTR_W     = 8;

  typedef logic [2:0] pg_code_t;

  localparam logic [1:0] KILL_ALL  = 2'd0;
  localparam logic [1:0] KILL_ASID = 2'd1;
  localparam logic [1:0] KILL_VMID = 2'd2;
  localparam logic [1:0] KILL_BOTH = 2'd3;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    pg_code_t          size;
    logic              global;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic [ATTR_W-1:0] attr;
  } xlat_entry_t;

  // Number of offset bits for a page size code.
  function automatic int page_shift(input pg_code_t code, input int big_shift);
    case (code)
      3'd1:    return 14;
      3'd2:    return 16;
      3'd3:    return 21;
      3'd4:    return big_shift;
      default: return BASE_SHIFT;
    endcase
  endfunction

  // Virtual page bits that take part in the tag compare.
  function automatic logic [VPN_W-1:0] vpn_keep(input pg_code_t code, input int big_shift);
    logic [VPN_W-1:0] m;
    int sh;
    sh = page_shift(code, big_shift);
    for (int i = 0; i < VPN_W; i++) m[i] = ((i + BASE_SHIFT) >= sh);
    return m;
  endfunction

  // Frame bits above the page size, virtual offset bits below it.
  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0] va,
                                              input pg_code_t code, input int big_shift);
    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] pa;
    int sh;
    sh    = page_shift(code, big_shift);
    frame = {pfn, {BASE_SHIFT{1'b0}}};
    for (int j = 0; j < PA_W; j++) pa[j] = (j < sh) ? va[j] : frame[j];
    return pa;
  endfunction

  // Whether an invalidate request removes an entry.
  function automatic logic kill_hits(input xlat_entry_t e, input logic [1:0] kind,
                                     input logic [ASID_W-1:0] asid,
                                     input logic [VMID_W-1:0] vmid);
    logic as_eq, vm_eq;
    as_eq = !e.global && (e.asid == asid);
    vm_eq = (e.vmid == vmid);
    case (kind)
      KILL_ALL:  return 1'b1;
      KILL_ASID: return as_eq;
      KILL_VMID: return vm_eq;
      default:   return as_eq && vm_eq;
    endcase
  endfunction
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp
  import xlat_pkg::*;
#(
  parameter int BIG_SHIFT = 25
) (
  input  xlat_entry_t       ent,
  input  logic [VPN_W-1:0]  va_vpn,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VMID_W-1:0] cur_vmid,
  output logic              match
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [VPN_W-1:0] keep;
  logic [VPN_W-1:0] diff;
  logic             ctx_ok;

  always_comb begin
    keep   = vpn_keep(ent.size, BIG_SHIFT);
    diff   = (ent.vpn ^ va_vpn) & keep;
    ctx_ok = (ent.vmid == cur_vmid) && (ent.global || (ent.asid == cur_asid));
    match  = ent.valid && ctx_ok && (diff == '0);
  end
endmodule

// File: rtl/xlat_hit_pick.sv
module xlat_hit_pick #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     match,
  output logic             any_hit,
  output logic             many_hit,
  output logic [IDX_W-1:0] idx
);
  timeunit 1ns;
  timeprecision 1ps;

  int cnt;

  always_comb begin
    idx = '0;
    cnt = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) cnt = cnt + (match[i] ? 1 : 0);
    any_hit  = |match;
    many_hit = (cnt > 1);
  end

  // R7
  lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (match[idx] && ((match & ~({N{1'b1}} << idx)) == '0)));

  // R7
  many_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    many_hit |-> any_hit);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             fill_fire,
  output logic [IDX_W-1:0] victim
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;
  logic             use_rr;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    has_free = ~&valid_vec;
    victim   = has_free ? free_idx : rr_q;
    use_rr   = fill_fire && !has_free;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_free |-> !valid_vec[victim]);

  // R8
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_rr |=> $stable(rr_q));

  // R9
  rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= IDX_W'(N - 1));
endmodule

// File: rtl/l1_xlat_buf.sv
module l1_xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES   = 48,
  parameter int BIG_SHIFT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [2:0]        fill_size,
  input  logic              fill_global,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              inv_valid,
  input  logic [1:0]        inv_kind,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VMID_W-1:0] inv_vmid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IDX_W = $clog2(ENTRIES);

  xlat_entry_t        ent_q [ENTRIES];
  xlat_entry_t        new_ent;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   hit_idx;
  logic               any_hit;
  logic               many_hit;

  // Per-entry tag compare
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    xlat_tag_cmp #(.BIG_SHIFT(BIG_SHIFT)) u_cmp (
      .ent      (ent_q[g]),
      .va_vpn   (lk_va[VA_W-1:BASE_SHIFT]),
      .cur_asid (lk_asid),
      .cur_vmid (lk_vmid),
      .match    (match_vec[g])
    );
  end

  xlat_hit_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match_vec),
    .any_hit  (any_hit),
    .many_hit (many_hit),
    .idx      (hit_idx)
  );

  xlat_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .fill_fire (fill_valid),
    .victim    (victim)
  );

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_vec[i] = ent_q[i].valid;
      kill_vec[i]  = inv_valid && kill_hits(ent_q[i], inv_kind, inv_asid, inv_vmid);
    end
    new_ent        = '0;
    new_ent.valid  = 1'b1;
    new_ent.vpn    = fill_vpn;
    new_ent.pfn    = fill_pfn;
    new_ent.size   = fill_size;
    new_ent.global = fill_global;
    new_ent.asid   = fill_asid;
    new_ent.vmid   = fill_vmid;
    new_ent.attr   = fill_attr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_valid && (victim == IDX_W'(i))) ent_q[i] <= new_ent;
        else if (kill_vec[i])                     ent_q[i].valid <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_hit   = lk_valid && any_hit;
    lk_multi = lk_valid && many_hit;
    walk_req = lk_valid && !any_hit;
    lk_pa    = '0;
    lk_attr  = '0;
    if (lk_hit) begin
      lk_pa   = join_pa(ent_q[hit_idx].pfn, lk_va, ent_q[hit_idx].size, BIG_SHIFT);
      lk_attr = ent_q[hit_idx].attr;
    end
  end

  // R12
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid_vec[$past(victim)]);

  // R10
  kill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == KILL_ALL && !fill_valid) |=> (valid_vec == '0));

  // R11
  for (genvar g = 0; g < ENTRIES; g++) begin : g_keep
    global_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == KILL_ASID && ent_q[g].valid && ent_q[g].global)
        |=> ent_q[g].valid);
  end

  // R6
  walk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!walk_req && !lk_hit && !lk_multi));
endmodule

// File: tb/l1_xlat_buf_test.sv
module l1_xlat_buf_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NE  = 48;
  localparam int BIG = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_va = '0;
  logic [15:0] lk_asid = '0, lk_vmid = '0;
  logic        lk_hit, lk_multi, walk_req;
  logic [39:0] lk_pa;
  logic [7:0]  lk_attr;
  logic        fill_valid = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_pfn = '0;
  logic [2:0]  fill_size = '0;
  logic        fill_global = 1'b0;
  logic [15:0] fill_asid = '0, fill_vmid = '0;
  logic [7:0]  fill_attr = '0;
  logic        inv_valid = 1'b0;
  logic [1:0]  inv_kind = '0;
  logic [15:0] inv_asid = '0, inv_vmid = '0;

  int total = 0;
  int fails = 0;

  // Reference state
  bit          m_v  [NE];
  logic [47:0] m_va [NE];
  logic [39:0] m_pa [NE];
  int          m_sh [NE];
  bit          m_g  [NE];
  logic [15:0] m_as [NE];
  logic [15:0] m_vm [NE];
  logic [7:0]  m_at [NE];
  int          m_rr;

  always #5 clk = ~clk;

  l1_xlat_buf #(.ENTRIES(NE), .BIG_SHIFT(BIG)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_vmid(lk_vmid), .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa),
    .lk_attr(lk_attr), .walk_req(walk_req), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_size(fill_size), .fill_global(fill_global),
    .fill_asid(fill_asid), .fill_vmid(fill_vmid), .fill_attr(fill_attr),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid), .inv_vmid(inv_vmid)
  );

  function automatic int size_bits(input logic [2:0] c);
    if (c == 3'd1) return 14;
    if (c == 3'd2) return 16;
    if (c == 3'd3) return 21;
    if (c == 3'd4) return BIG;
    return 12;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic compare(input string tag);
    int nm;
    logic [39:0] e_pa;
    logic [7:0]  e_at;
    logic        e_hit, e_multi, e_walk;
    nm = 0; e_pa = '0; e_at = '0;
    if (lk_valid) begin
      for (int i = 0; i < NE; i++) begin
        if (m_v[i] && m_vm[i] == lk_vmid && (m_g[i] || m_as[i] == lk_asid) &&
            ((m_va[i] >> m_sh[i]) == (lk_va >> m_sh[i]))) begin
          if (nm == 0) begin
            e_pa = ((m_pa[i] >> m_sh[i]) << m_sh[i]) |
                   40'(lk_va & ((48'd1 << m_sh[i]) - 48'd1));
            e_at = m_at[i];
          end
          nm++;
        end
      end
    end
    e_hit = (nm > 0); e_multi = (nm > 1); e_walk = lk_valid && (nm == 0);
    total++;
    if (lk_hit !== e_hit || lk_multi !== e_multi || walk_req !== e_walk ||
        lk_pa !== e_pa || lk_attr !== e_at) begin
      fails++;
      $display("FAIL %s: hit=%b multi=%b walk=%b pa=%h attr=%h expected hit=%b multi=%b walk=%b pa=%h attr=%h",
               tag, lk_hit, lk_multi, walk_req, lk_pa, lk_attr,
               e_hit, e_multi, e_walk, e_pa, e_at);
    end
  endtask

  task automatic model_edge();
    int vic;
    bit found;
    vic = 0; found = 0;
    if (fill_valid) begin
      for (int i = 0; i < NE; i++) if (!found && !m_v[i]) begin vic = i; found = 1; end
      if (!found) begin vic = m_rr; m_rr = (m_rr + 1) % NE; end
    end
    if (inv_valid) begin
      for (int i = 0; i < NE; i++) begin
        case (inv_kind)
          2'd0: m_v[i] = 0;
          2'd1: if (!m_g[i] && m_as[i] == inv_asid) m_v[i] = 0;
          2'd2: if (m_vm[i] == inv_vmid) m_v[i] = 0;
          default: if (!m_g[i] && m_as[i] == inv_asid && m_vm[i] == inv_vmid) m_v[i] = 0;
        endcase
      end
    end
    if (fill_valid) begin
      m_v[vic]  = 1;
      m_va[vic] = {fill_vpn, 12'h000};
      m_pa[vic] = {fill_pfn, 12'h000};
      m_sh[vic] = size_bits(fill_size);
      m_g[vic]  = fill_global;
      m_as[vic] = fill_asid;
      m_vm[vic] = fill_vmid;
      m_at[vic] = fill_attr;
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    compare(tag);
    model_edge();
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    inv_valid  = 1'b0;
  endtask

  task automatic set_look(input logic [47:0] va, input logic [15:0] as, input logic [15:0] vm);
    lk_valid = 1'b1; lk_va = va; lk_asid = as; lk_vmid = vm;
  endtask

  task automatic set_fill(input logic [47:0] va, input logic [39:0] pa, input logic [2:0] sz,
                          input bit g, input logic [15:0] as, input logic [15:0] vm,
                          input logic [7:0] at);
    fill_valid = 1'b1; fill_vpn = va[47:12]; fill_pfn = pa[39:12]; fill_size = sz;
    fill_global = g; fill_asid = as; fill_vmid = vm; fill_attr = at;
  endtask

  task automatic set_inv(input logic [1:0] k, input logic [15:0] as, input logic [15:0] vm);
    inv_valid = 1'b1; inv_kind = k; inv_asid = as; inv_vmid = vm;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_va[i] = '0; m_pa[i] = '0; m_sh[i] = 12;
      m_g[i] = 0; m_as[i] = '0; m_vm[i] = '0; m_at[i] = '0;
    end
    m_rr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state: valid lookup misses and asks for a walk
    set_look(48'h0012_3456_7000, 16'h0011, 16'h0003); tick("R1");
    // R6 idle lookup port
    lk_valid = 1'b0; tick("R6");

    // R3 one entry per size code, plus an undefined code
    set_fill(48'h0000_1000_0000, 40'h12_3456_7000, 3'd0, 0, 16'h0011, 16'h0003, 8'hA0); tick("R8");
    set_fill(48'h0000_2000_0000, 40'h22_2222_0000, 3'd1, 0, 16'h0011, 16'h0003, 8'hA1); tick("R8");
    set_fill(48'h0000_3000_0000, 40'h33_3330_0000, 3'd2, 0, 16'h0011, 16'h0003, 8'hA2); tick("R8");
    set_fill(48'h0000_4000_0000, 40'h44_4400_0000, 3'd3, 0, 16'h0011, 16'h0003, 8'hA3); tick("R8");
    set_fill(48'h0000_6000_0000, 40'h56_0000_0000, 3'd4, 0, 16'h0011, 16'h0003, 8'hA4); tick("R8");
    set_fill(48'h0000_8000_0000, 40'h66_6666_6000, 3'd6, 0, 16'h0011, 16'h0003, 8'hA5); tick("R8");

    // R3 R4 R5 edges of each page
    set_look(48'h0000_1000_0FFF, 16'h0011, 16'h0003); tick("R4");
    set_look(48'h0000_1000_1000, 16'h0011, 16'h0003); tick("R3");
    set_look(48'h0000_2000_3ABC, 16'h0011, 16'h0003); tick("R4");
    set_look(48'h0000_2000_4000, 16'h0011, 16'h0003); tick("R3");
    set_look(48'h0000_3000_FFFF, 16'h0011, 16'h0003); tick("R4");
    set_look(48'h0000_3001_0000, 16'h0011, 16'h0003); tick("R3");
    set_look(48'h0000_401F_FFFF, 16'h0011, 16'h0003); tick("R4");
    set_look(48'h0000_4020_0000, 16'h0011, 16'h0003); tick("R3");
    set_look(48'h0000_61FF_FFFF, 16'h0011, 16'h0003); tick("R4");
    set_look(48'h0000_6200_0000, 16'h0011, 16'h0003); tick("R3");
    set_look(48'h0000_8000_0800, 16'h0011, 16'h0003); tick("R5");
    set_look(48'h0000_8000_1000, 16'h0011, 16'h0003); tick("R3");

    // R2 context tags: a global entry whose own ASID is 0x0011
    set_fill(48'h0000_A000_0000, 40'h0A_0000_0000, 3'd0, 1, 16'h0011, 16'h0003, 8'hB6); tick("R8");
    set_look(48'h0000_1000_0010, 16'h0012, 16'h0003); tick("R2");
    set_look(48'h0000_A000_0010, 16'h0099, 16'h0003); tick("R2");
    set_look(48'h0000_1000_0010, 16'h0011, 16'h0004); tick("R2");
    set_look(48'h0000_A000_0010, 16'h0011, 16'h0004); tick("R2");

    // R7 duplicate page, lower index supplies data
    set_fill(48'h0000_1000_0000, 40'h77_7777_7000, 3'd0, 0, 16'h0011, 16'h0003, 8'hC7); tick("R8");
    set_look(48'h0000_1000_0234, 16'h0011, 16'h0003); tick("R7");

    // R10 R11 kill by ASID
    set_inv(2'd1, 16'h0011, 16'h0000); tick("R10");
    set_look(48'h0000_A000_0044, 16'h0055, 16'h0003); tick("R11");
    set_look(48'h0000_1000_0044, 16'h0011, 16'h0003); tick("R10");

    // R10 kill by both tags, then by VMID
    set_fill(48'h0000_C000_0000, 40'h0C_0000_0000, 3'd0, 0, 16'h0022, 16'h0005, 8'hD0); tick("R8");
    set_fill(48'h0000_D000_0000, 40'h0D_0000_0000, 3'd0, 0, 16'h0022, 16'h0003, 8'hD1); tick("R8");
    set_inv(2'd3, 16'h0022, 16'h0005); tick("R10");
    set_look(48'h0000_C000_0000, 16'h0022, 16'h0005); tick("R10");
    set_look(48'h0000_D000_0000, 16'h0022, 16'h0003); tick("R10");
    set_inv(2'd2, 16'h0000, 16'h0003); tick("R10");
    set_look(48'h0000_A000_0000, 16'h0022, 16'h0003); tick("R10");

    // R9 fill past capacity, wrap the pointer
    set_inv(2'd0, 16'h0000, 16'h0000); tick("R10");
    for (int k = 0; k < 97; k++) begin
      set_fill(48'h0010_0000_0000 + 48'(k) * 48'h1000, 40'h40_0000_0000 + 40'(k) * 40'h1000,
               3'd0, 0, 16'h0033, 16'h0007, 8'(k));
      set_look(48'h0010_0000_0000 + 48'(k / 2) * 48'h1000 + 48'h0ABC, 16'h0033, 16'h0007);
      tick("R9");
    end
    set_look(48'h0010_0003_0000, 16'h0033, 16'h0007); tick("R9");
    set_look(48'h0010_0003_1000, 16'h0033, 16'h0007); tick("R9");
    set_look(48'h0010_0006_0000, 16'h0033, 16'h0007); tick("R9");
    set_look(48'h0010_0001_4000, 16'h0033, 16'h0007); tick("R9");
    set_look(48'h0010_0001_3000, 16'h0033, 16'h0007); tick("R9");

    // R12 fill and kill-all together on a full array
    set_fill(48'h0020_0000_0000, 40'h5A_5A5A_5000, 3'd2, 0, 16'h0033, 16'h0007, 8'hEE);
    set_inv(2'd0, 16'h0000, 16'h0000);
    set_look(48'h0010_0003_1000, 16'h0033, 16'h0007); tick("R12");
    set_look(48'h0020_0000_1234, 16'h0033, 16'h0007); tick("R12");
    set_look(48'h0010_0003_1000, 16'h0033, 16'h0007); tick("R12");
    lk_valid = 1'b0; tick("R6");

    summary();
    $finish;
  end
endmodule